// File: doc/BRIEF.md
# Multi-Level Interrupt Controller

This block is the interrupt front end of a small processor core. It watches five request lines: a non-maskable emergency line, an edge-latched vectored line, two level-sensitive vectored lines and one level-sensitive line whose vector comes from an external device. It holds a global enable flag, three per-line mask bits, a memory flop for the edge-latched line and a one-bit serial output.

The core drives a boundary strobe once per instruction. On each strobed clock edge the block picks the highest-priority request that is acceptable at that moment. One cycle later it raises a single-cycle take pulse. With the pulse it gives either a fixed vector address or, for the external-vector line, an acknowledge so that a device can put the address on the bus.

Software reaches the block through enable and disable strobes, a byte-wide mask-write port and a byte-wide status word. The call sequence, the stack and instruction execution belong to the core, not to this block.

Top module: `irq_prio_unit`

## Requirements
- R1: After reset the enable flag is 0, all three masks are 1 (masked), the edge memory is 0, `sod_o` is 0 and `take_o` is 0. With all inputs low, `stat_o` reads 0x07.
- R2: `ei_i` sets the enable flag on the next edge and `di_i` clears it. If both are high, disable wins. While the flag is 0, no request except the emergency line is accepted.
- R3: On a mask write, bits 2:0 of `mwr_data_i` load the masks for the high-edge, mid and low lines (bit 2, 1, 0; 1 = masked). They load only when bit 3 is 1; otherwise the masks keep their value. Bit 5 has no effect.
- R4: On a mask write, bit 4 = 1 clears the edge memory. Bit 6 = 1 copies bit 7 to `sod_o`; with bit 6 = 0, bit 7 has no effect and `sod_o` holds.
- R5: `stat_o` is combinational: bits 2:0 are the masks, bit 3 is the enable flag, bit 4 is the raw low-line pin, bit 5 is the raw mid-line pin, bit 6 is the edge memory and bit 7 is `sid_i`.
- R6: A rising edge on `req_edge_i` sets the edge memory on that clock edge, even while that line is masked. The memory stays set after the pin falls. Holding the pin high never sets it again once cleared: the pin must fall and rise first.
- R7: `req_mid_i`, `req_low_i` and `req_ext_i` are accepted only if they are high at the strobed edge.
- R8: Priority, from highest to lowest: emergency (vector 0x0024), edge line (0x003C), mid line (0x0034), low line (0x002C), external line (`ext_ack_o` = 1 with vector 0x0000). Exactly one source is taken per strobe.
- R9: The emergency line ignores the enable flag and the masks. It is accepted only if a rising edge was seen on an earlier clock edge and the line has stayed high up to the strobe. After it is taken, or if it drops, the line must fall and rise again before it can be taken again.
- R10: Taking any maskable source clears the enable flag, and this wins over a simultaneous `ei_i`. Taking the edge line also clears the edge memory. Taking the emergency line leaves the enable flag unchanged.
- R11: `take_o` is a one-cycle pulse, high only in the cycle after a strobed edge with an acceptable request. It is never high without a preceding strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_trap_i | input | 1 | Non-maskable emergency request |
| req_edge_i | input | 1 | Edge-latched vectored request (highest maskable) |
| req_mid_i | input | 1 | Level vectored request, middle priority |
| req_low_i | input | 1 | Level vectored request, low priority |
| req_ext_i | input | 1 | Level request with externally supplied vector |
| bnd_i | input | 1 | Instruction-boundary strobe |
| ei_i | input | 1 | Enable-interrupts strobe |
| di_i | input | 1 | Disable-interrupts strobe |
| mwr_i | input | 1 | Mask-write strobe |
| mwr_data_i | input | 8 | Mask-write data |
| sid_i | input | 1 | Serial data in, reported in status |
| stat_o | output | 8 | Status word |
| sod_o | output | 1 | Serial data out |
| take_o | output | 1 | Interrupt taken pulse |
| take_vec_o | output | VEC_W | Vector of the taken source |
| ext_ack_o | output | 1 | Acknowledge for the external-vector source |

## Verification
Status bits that mirror pins and `sid_i` are checked in the same cycle the pin changes. Register-backed status and `sod_o` are checked one clock edge after the strobe that changes them. `take_o`, `take_vec_o` and `ext_ack_o` are checked exactly one edge after the strobed boundary. The bench drives every input on a falling edge and samples on the next falling edge, so each check sees exactly one rising edge of effect. A request that rises on the strobed edge itself has not yet been latched or armed, so the bench expects no take on that edge and a take on the next strobe.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int NSRC     = 5;
   localparam int NMASK    = 3;
   // source index: higher index wins arbitration
   localparam int IX_EXT   = 0;
   localparam int IX_LOW   = 1;
   localparam int IX_MID   = 2;
   localparam int IX_EDGE  = 3;
   localparam int IX_TRAP  = 4;
   // mask-write byte fields
   localparam int WB_MSEN  = 3;
   localparam int WB_LCLR  = 4;
   localparam int WB_SOE   = 6;
   localparam int WB_SOD   = 7;
   // status byte fields
   localparam int SB_IEN   = 3;
   localparam int SB_PLOW  = 4;
   localparam int SB_PMID  = 5;
   localparam int SB_LEDGE = 6;
   localparam int SB_SID   = 7;
endpackage

// File: rtl/irq_rise_latch.sv
module irq_rise_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   input  logic clr_i,
   output logic pend_o
);
   logic line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= 1'b0;
         pend_o <= 1'b0;
      end else begin
         line_q <= line_i;
         if (line_i && !line_q)
            pend_o <= 1'b1;        // a new edge beats any clear
         else if (clr_i)
            pend_o <= 1'b0;
      end
   end

   a_r6_rise_records: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_i) |=> pend_o);
endmodule

// File: rtl/irq_trap_sense.sv
module irq_trap_sense (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   input  logic taken_i,
   output logic pend_o
);
   logic line_q;
   logic arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= 1'b0;
         arm_q  <= 1'b0;
      end else begin
         line_q <= line_i;
         if (!line_i || taken_i)
            arm_q <= 1'b0;
         else if (!line_q)
            arm_q <= 1'b1;
      end
   end

   assign pend_o = arm_q & line_i;

   a_r9_armed_after_high: assert property (@(posedge clk) disable iff (!rst_n)
      pend_o |-> $past(line_i));
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
   import irq_pkg::*;
#(
   parameter int NM = NMASK
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ei_i,
   input  logic          di_i,
   input  logic          wr_i,
   input  logic [7:0]    wd_i,
   input  logic          mtake_i,
   output logic          ien_o,
   output logic [NM-1:0] mask_o,
   output logic          sod_o
);
   localparam logic [NM-1:0] MASK_RST = '1;

   if (NM > WB_MSEN) begin : g_bad_nm
      $error("mask count overlaps the mask-set-enable bit");
   end

   logic load_mask;
   logic load_sod;

   assign load_mask = wr_i & wd_i[WB_MSEN];
   assign load_sod  = wr_i & wd_i[WB_SOE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_o  <= 1'b0;
         mask_o <= MASK_RST;
         sod_o  <= 1'b0;
      end else begin
         if (di_i || mtake_i)
            ien_o <= 1'b0;
         else if (ei_i)
            ien_o <= 1'b1;
         if (load_mask)
            mask_o <= wd_i[NM-1:0];
         if (load_sod)
            sod_o <= wd_i[WB_SOD];
      end
   end

   a_r2_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
      di_i |=> !ien_o);
   a_r3_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !wd_i[WB_MSEN]) |=> $stable(mask_o));
   a_r4_sod_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_i && wd_i[WB_SOE]) |=> $stable(sod_o));
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
   parameter int                    NSRC     = 5,
   parameter int                    VEC_W    = 16,
   parameter int                    EXT_IX   = 0,
   parameter bit                    HOLD_VEC = 1'b0,
   parameter logic [NSRC*VEC_W-1:0] VECS     = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bnd_i,
   input  logic [NSRC-1:0]  req_i,
   output logic [NSRC-1:0]  gnt_o,
   output logic [NSRC-1:0]  gq_o,
   output logic             vld_o,
   output logic             ext_o,
   output logic [VEC_W-1:0] vec_o
);
   logic [NSRC-1:0]  win;
   logic [VEC_W-1:0] vec_n;

   for (genvar i = 0; i < NSRC; i++) begin : g_win
      if (i == NSRC-1) begin : g_top
         assign win[i] = req_i[i];
      end else begin : g_low
         assign win[i] = req_i[i] & ~(|req_i[NSRC-1:i+1]);
      end
   end

   assign gnt_o = bnd_i ? win : '0;

   always_comb begin
      vec_n = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (win[i] && i != EXT_IX)
            vec_n = VECS[i*VEC_W +: VEC_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
         ext_o <= 1'b0;
         gq_o  <= '0;
      end else begin
         vld_o <= |gnt_o;
         ext_o <= gnt_o[EXT_IX];
         gq_o  <= gnt_o;
      end
   end

   if (HOLD_VEC) begin : g_vec_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            vec_o <= '0;
         else if (|gnt_o)
            vec_o <= vec_n;
      end
   end else begin : g_vec_zero
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            vec_o <= '0;
         else
            vec_o <= (|gnt_o) ? vec_n : '0;
      end
   end

   a_r8_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gq_o));
   a_r11_pulse_after_bnd: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |-> $past(bnd_i));
endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit
   import irq_pkg::*;
#(
   parameter int          VEC_W    = 16,
   parameter logic [31:0] TRAP_VEC = 32'h0000_0024,
   parameter logic [31:0] EDGE_VEC = 32'h0000_003C,
   parameter logic [31:0] MID_VEC  = 32'h0000_0034,
   parameter logic [31:0] LOW_VEC  = 32'h0000_002C,
   parameter bit          HOLD_VEC = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_trap_i,
   input  logic             req_edge_i,
   input  logic             req_mid_i,
   input  logic             req_low_i,
   input  logic             req_ext_i,
   input  logic             bnd_i,
   input  logic             ei_i,
   input  logic             di_i,
   input  logic             mwr_i,
   input  logic [7:0]       mwr_data_i,
   input  logic             sid_i,
   output logic [7:0]       stat_o,
   output logic             sod_o,
   output logic             take_o,
   output logic [VEC_W-1:0] take_vec_o,
   output logic             ext_ack_o
);
   localparam logic [NSRC*VEC_W-1:0] VECS =
      {VEC_W'(TRAP_VEC), VEC_W'(EDGE_VEC), VEC_W'(MID_VEC), VEC_W'(LOW_VEC), VEC_W'(0)};

   if (VEC_W < 8 || VEC_W > 31) begin : g_bad_w
      $error("vector width out of range");
   end
   if ((TRAP_VEC >> VEC_W) != 0 || (EDGE_VEC >> VEC_W) != 0 ||
       (MID_VEC >> VEC_W) != 0 || (LOW_VEC >> VEC_W) != 0) begin : g_bad_fit
      $error("a fixed vector does not fit the vector width");
   end
   if (TRAP_VEC == 0 || EDGE_VEC == 0 || MID_VEC == 0 || LOW_VEC == 0) begin : g_bad_zero
      $error("zero is reserved for the external-vector source");
   end
   if (TRAP_VEC == EDGE_VEC || EDGE_VEC == MID_VEC || MID_VEC == LOW_VEC ||
       TRAP_VEC == MID_VEC || TRAP_VEC == LOW_VEC || EDGE_VEC == LOW_VEC) begin : g_bad_dup
      $error("fixed vectors must be distinct");
   end

   logic             ien;
   logic [NMASK-1:0] mask;
   logic             edge_pend;
   logic             trap_pend;
   logic [NSRC-1:0]  req;
   logic [NSRC-1:0]  gnt;
   logic [NSRC-1:0]  gq;
   logic             mtake;
   logic             edge_clr;
   logic [NMASK-1:0] vlvl;

   assign vlvl = {edge_pend, req_mid_i, req_low_i};

   // the three vectored maskable sources share one gating pattern
   for (genvar k = 0; k < NMASK; k++) begin : g_gate
      assign req[IX_LOW + k] = ien & ~mask[k] & vlvl[k];
   end
   assign req[IX_EXT]  = ien & req_ext_i;
   assign req[IX_TRAP] = trap_pend;

   assign mtake    = |gnt[IX_EDGE:IX_EXT];
   assign edge_clr = gnt[IX_EDGE] | (mwr_i & mwr_data_i[WB_LCLR]);

   irq_trap_sense u_trap (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_i  (req_trap_i),
      .taken_i (gnt[IX_TRAP]),
      .pend_o  (trap_pend)
   );

   irq_rise_latch u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (req_edge_i),
      .clr_i  (edge_clr),
      .pend_o (edge_pend)
   );

   irq_ctrl_regs #(.NM(NMASK)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .ei_i    (ei_i),
      .di_i    (di_i),
      .wr_i    (mwr_i),
      .wd_i    (mwr_data_i),
      .mtake_i (mtake),
      .ien_o   (ien),
      .mask_o  (mask),
      .sod_o   (sod_o)
   );

   irq_prio_arb #(
      .NSRC     (NSRC),
      .VEC_W    (VEC_W),
      .EXT_IX   (IX_EXT),
      .HOLD_VEC (HOLD_VEC),
      .VECS     (VECS)
   ) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .bnd_i (bnd_i),
      .req_i (req),
      .gnt_o (gnt),
      .gq_o  (gq),
      .vld_o (take_o),
      .ext_o (ext_ack_o),
      .vec_o (take_vec_o)
   );

   always_comb begin
      stat_o                = '0;
      stat_o[NMASK-1:0]     = mask;
      stat_o[SB_IEN]        = ien;
      stat_o[SB_PLOW]       = req_low_i;
      stat_o[SB_PMID]       = req_mid_i;
      stat_o[SB_LEDGE]      = edge_pend;
      stat_o[SB_SID]        = sid_i;
   end

   a_r10_enable_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && !gq[IX_TRAP]) |-> !ien);
   a_r9_trap_was_high: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && gq[IX_TRAP]) |-> $past(req_trap_i));
   a_r7_level_was_high: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && gq[IX_MID]) |-> $past(req_mid_i));
endmodule

// File: tb/sim_irq_prio_unit.sv
module sim_irq_prio_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_trap_i = 1'b0, req_edge_i = 1'b0, req_mid_i = 1'b0;
   logic        req_low_i = 1'b0, req_ext_i = 1'b0;
   logic        bnd_i = 1'b0, ei_i = 1'b0, di_i = 1'b0, mwr_i = 1'b0;
   logic [7:0]  mwr_data_i = '0;
   logic        sid_i = 1'b0;
   logic [7:0]  stat_o;
   logic        sod_o, take_o, ext_ack_o;
   logic [15:0] take_vec_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   irq_prio_unit u0 (
      .clk (clk), .rst_n (rst_n),
      .req_trap_i (req_trap_i), .req_edge_i (req_edge_i), .req_mid_i (req_mid_i),
      .req_low_i (req_low_i), .req_ext_i (req_ext_i),
      .bnd_i (bnd_i), .ei_i (ei_i), .di_i (di_i),
      .mwr_i (mwr_i), .mwr_data_i (mwr_data_i), .sid_i (sid_i),
      .stat_o (stat_o), .sod_o (sod_o), .take_o (take_o),
      .take_vec_o (take_vec_o), .ext_ack_o (ext_ack_o)
   );

   // ln order: {trap, edge, mid, low, ext}
   typedef struct packed {
      logic [4:0]  ln;
      logic        ei, di, wr;
      logic [7:0]  wd;
      logic        bnd;
      logic        e_take, e_ack;
      logic [15:0] e_vec;
      logic [7:0]  e_st;
      logic        e_sod;
   } row_t;

   function automatic row_t mk(logic [4:0] ln, logic ei, logic di, logic wr,
                               logic [7:0] wd, logic bnd, logic tk, logic ak,
                               logic [15:0] vec, logic [7:0] st, logic so);
      row_t r;
      r.ln = ln; r.ei = ei; r.di = di; r.wr = wr; r.wd = wd; r.bnd = bnd;
      r.e_take = tk; r.e_ack = ak; r.e_vec = vec; r.e_st = st; r.e_sod = so;
      return r;
   endfunction

   localparam int NROW = 14;
   localparam row_t TBL [NROW] = '{
      mk(5'b00000, 1, 0, 0, 8'h00, 0, 0, 0, 16'h0000, 8'h0F, 0), // R2 enable
      mk(5'b00000, 0, 0, 1, 8'h0A, 0, 0, 0, 16'h0000, 8'h0A, 0), // R3 load masks
      mk(5'b01000, 0, 0, 0, 8'h00, 0, 0, 0, 16'h0000, 8'h4A, 0), // R6 edge latched
      mk(5'b01000, 0, 0, 0, 8'h00, 1, 1, 0, 16'h003C, 8'h02, 0), // R10 edge taken
      mk(5'b01000, 1, 0, 0, 8'h00, 0, 0, 0, 16'h0000, 8'h0A, 0), // R6 held high
      mk(5'b01110, 0, 0, 0, 8'h00, 1, 1, 0, 16'h002C, 8'h32, 0), // R3 mid masked
      mk(5'b00011, 1, 0, 0, 8'h00, 0, 0, 0, 16'h0000, 8'h1A, 0), // R5 raw pins
      mk(5'b00001, 0, 0, 0, 8'h00, 1, 1, 1, 16'h0000, 8'h02, 0), // R8 external
      mk(5'b00000, 1, 0, 1, 8'h08, 0, 0, 0, 16'h0000, 8'h08, 0), // R3 unmask all
      mk(5'b01101, 0, 0, 0, 8'h00, 1, 1, 0, 16'h0034, 8'h60, 0), // R8 mid over ext
      mk(5'b01000, 0, 0, 1, 8'h10, 0, 0, 0, 16'h0000, 8'h00, 0), // R4 clear memory
      mk(5'b00000, 0, 0, 1, 8'hC0, 0, 0, 0, 16'h0000, 8'h00, 1), // R4 serial out 1
      mk(5'b00000, 0, 0, 1, 8'hA0, 0, 0, 0, 16'h0000, 8'h00, 1), // R4 bit7 ignored
      mk(5'b00000, 0, 0, 1, 8'h47, 0, 0, 0, 16'h0000, 8'h00, 0)  // R3 masks kept
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // called at a falling edge; drives, lets one rising edge pass, returns at next falling edge
   task automatic cyc(input logic [4:0] ln, input logic ei, input logic di,
                      input logic wr, input logic [7:0] wd, input logic bnd);
      {req_trap_i, req_edge_i, req_mid_i, req_low_i, req_ext_i} = ln;
      ei_i = ei; di_i = di; mwr_i = wr; mwr_data_i = wd; bnd_i = bnd;
      @(negedge clk);
   endtask

   task automatic take_chk(input string tag, input logic tk, input logic ak,
                           input logic [15:0] vec);
      chk({tag, " take"}, take_o, tk);
      chk({tag, " ack"}, ext_ack_o, ak);
      if (tk) chk({tag, " vec"}, take_vec_o, vec);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 status", stat_o, 8'h07);
      chk("R1 sod", sod_o, 1'b0);
      chk("R1 take", take_o, 1'b0);

      for (int i = 0; i < NROW; i++) begin
         cyc(TBL[i].ln, TBL[i].ei, TBL[i].di, TBL[i].wr, TBL[i].wd, TBL[i].bnd);
         take_chk($sformatf("R8 row%0d", i), TBL[i].e_take, TBL[i].e_ack, TBL[i].e_vec);
         chk($sformatf("R5 row%0d status", i), stat_o, TBL[i].e_st);
         chk($sformatf("R4 row%0d sod", i), sod_o, TBL[i].e_sod);
      end
      cyc(5'b00000, 0, 0, 0, 8'h00, 0);

      // R5 serial input bit
      sid_i = 1'b1;
      #1;
      chk("R5 sid bit", stat_o, 8'h80);
      sid_i = 1'b0;
      @(negedge clk);

      // R2 disable beats enable
      cyc(5'b00000, 1, 1, 0, 8'h00, 0); chk("R2 both", stat_o, 8'h00);
      cyc(5'b00000, 1, 0, 0, 8'h00, 0); chk("R2 ei", stat_o, 8'h08);
      cyc(5'b00000, 0, 1, 0, 8'h00, 0); chk("R2 di", stat_o, 8'h00);

      // R7 / R2: level request blocked while disabled
      cyc(5'b00001, 0, 0, 0, 8'h00, 1); take_chk("R7 disabled", 0, 0, 0);

      // R9 emergency edge plus level
      cyc(5'b00000, 1, 0, 0, 8'h00, 0);
      cyc(5'b10000, 0, 0, 0, 8'h00, 1); take_chk("R9 same edge", 0, 0, 0);
      cyc(5'b10000, 0, 0, 0, 8'h00, 1); take_chk("R9 armed", 1, 0, 16'h0024);
      chk("R10 trap keeps ien", stat_o, 8'h08);
      cyc(5'b10000, 0, 0, 0, 8'h00, 1); take_chk("R9 no repeat", 0, 0, 0);
      cyc(5'b00000, 0, 0, 0, 8'h00, 0);
      cyc(5'b10000, 0, 0, 0, 8'h00, 0);
      cyc(5'b00000, 0, 0, 0, 8'h00, 1); take_chk("R9 dropped", 0, 0, 0);
      cyc(5'b10000, 0, 0, 0, 8'h00, 0);
      cyc(5'b10000, 0, 0, 0, 8'h00, 1); take_chk("R9 fresh edge", 1, 0, 16'h0024);
      cyc(5'b00000, 0, 0, 0, 8'h00, 0); take_chk("R11 one pulse", 0, 0, 0);

      // R8 full priority ladder
      cyc(5'b11000, 0, 0, 0, 8'h00, 0);
      cyc(5'b11111, 0, 0, 0, 8'h00, 1); take_chk("R8 trap first", 1, 0, 16'h0024);
      cyc(5'b11111, 0, 0, 0, 8'h00, 1); take_chk("R8 edge second", 1, 0, 16'h003C);
      chk("R10 edge clears", stat_o, 8'h30);
      cyc(5'b11111, 1, 0, 0, 8'h00, 0);
      cyc(5'b11111, 0, 0, 0, 8'h00, 1); take_chk("R8 mid third", 1, 0, 16'h0034);
      cyc(5'b11011, 1, 0, 0, 8'h00, 0);
      cyc(5'b11011, 0, 0, 0, 8'h00, 1); take_chk("R8 low fourth", 1, 0, 16'h002C);
      cyc(5'b11001, 1, 0, 0, 8'h00, 0);
      cyc(5'b11001, 0, 0, 0, 8'h00, 1); take_chk("R8 ext last", 1, 1, 16'h0000);
      cyc(5'b00000, 0, 0, 0, 8'h00, 0);

      // R6 memory survives masking
      cyc(5'b00000, 1, 0, 1, 8'h0C, 0);
      cyc(5'b01000, 0, 0, 0, 8'h00, 0);
      cyc(5'b01000, 0, 0, 0, 8'h00, 1); take_chk("R6 masked", 0, 0, 0);
      chk("R6 memory held", stat_o, 8'h4C);
      cyc(5'b00000, 0, 0, 1, 8'h08, 0); chk("R6 unmasked", stat_o, 8'h48);
      cyc(5'b00000, 0, 0, 0, 8'h00, 1); take_chk("R6 late take", 1, 0, 16'h003C);
      cyc(5'b00000, 0, 0, 0, 8'h00, 0); take_chk("R11 no strobe", 0, 0, 0);
      chk("R10 after edge", stat_o, 8'h00);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule